// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two integers held in sign-and-magnitude form and returns the result in the same form. It is purely combinational. Each operand word holds a sign flag in its top bit and an unsigned absolute value in the bits below it. A one-bit operation select chooses between sum and difference. A difference is formed by inverting the sign of the second operand and then adding.

The data path depends on the signs. If the effective signs agree, the two magnitudes are summed and the shared sign is kept. A carry out of that sum means the true result does not fit, and the overflow output is raised. If the signs disagree, a magnitude comparator picks the larger operand, the smaller magnitude is taken from it, and the larger operand's sign is kept. A cancellation to zero always comes out as the all-zeros word.

It is meant to sit inside a wider arithmetic path that stores values in sign-and-magnitude form. In that form negation is a flip of the top bit and the range is symmetric about zero.

Top module: `smas_addsub`

## Requirements
- R1: Bit WIDTH-1 of every operand and of the result is the sign (1 = negative). Bits WIDTH-2..0 are the unsigned magnitude, so values span -(2^(WIDTH-1)-1) to +(2^(WIDTH-1)-1).
- R2: When the sign of A equals the effective sign of B, the result magnitude is the low WIDTH-1 bits of magA+magB, and the result sign is that common sign.
- R3: When the effective signs are equal, `overflow` is 1 exactly when magA+magB exceeds 2^(WIDTH-1)-1. For example, with WIDTH=5, +11 plus +6 gives overflow=1 and result 5'b00001.
- R4: When the effective signs differ and the magnitudes are unequal, the result magnitude is the larger minus the smaller. The result sign is that of the operand with the larger magnitude. For example, +11 plus -6 gives +5.
- R5: When the effective signs differ and the magnitudes are equal, the result is the plus-zero word (all bits 0).
- R6: `overflow` is 0 whenever the effective signs differ.
- R7: `sub_op`=1 (subtract) inverts the sign bit of B before any other step, and `sub_op`=0 (add) leaves it unchanged. A minus B therefore equals A plus (B with its top bit flipped).
- R8: Minus zero (only the sign bit set) is treated as magnitude 0 with its sign. Minus zero plus minus zero gives minus zero, and minus zero plus +5 gives +5.
- R9: Whenever `overflow` is 0, the signed value of the result equals the signed value of A plus, or minus, the signed value of B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_op | input | 1 | 0 = add, 1 = subtract |
| opnd_a | input | WIDTH | First operand, sign-and-magnitude |
| opnd_b | input | WIDTH | Second operand, sign-and-magnitude |
| result | output | WIDTH | Sum or difference, sign-and-magnitude |
| overflow | output | 1 | Magnitude sum did not fit (same-sign case only) |

## Verification
The bench builds the block with WIDTH=5, which gives a 4-bit magnitude. At that width every combination of operation, operand A and operand B (2048 cases) can be swept in full. The sweep covers both zero encodings, the largest magnitudes on both sides, every carry that wraps, and every tie that must fold to plus zero. A short table of worked cases pins down the specific examples named in the requirements before the sweep runs.

// File: rtl/smas_pkg.sv
// Shared definitions for the signed-magnitude adder/subtractor.
// Assumes nothing beyond a 1-bit operation select.
package smas_pkg;

    // Operation select encoding seen on the sub_op port.
    typedef enum logic {
        SMAS_ADD = 1'b0,
        SMAS_SUB = 1'b1
    } smas_op_e;

endpackage

// File: rtl/smas_sign_route.sv
// Sign routing: applies the operation to the second operand's sign and
// reports whether the two effective signs agree.
// Assumes: op has already been decoded to smas_op_e.
module smas_sign_route
    import smas_pkg::*;
(
    input  logic     a_sign,
    input  logic     b_sign,
    input  smas_op_e op,
    output logic     eff_b_sign,
    output logic     same_sign
);

    // Invert B's sign for subtraction, then compare the signs.
    always_comb begin
        eff_b_sign = b_sign ^ (op == SMAS_SUB);
        same_sign  = (a_sign == eff_b_sign);
    end

endmodule

// File: rtl/smas_mag_cmp.sv
// Magnitude comparator: scans from the most significant bit downward and
// reports whether A's magnitude is at least B's and whether they tie.
// Assumes: both magnitudes are unsigned and MAG_W bits wide.
module smas_mag_cmp #(
    parameter int MAG_W = 7
) (
    input  logic [MAG_W-1:0] a_mag,
    input  logic [MAG_W-1:0] b_mag,
    output logic             a_ge_b,
    output logic             mag_tie
);

    // Per-bit decision chain: gt/lt resolved at the highest differing bit.
    logic [MAG_W:0] gt_chain;
    logic [MAG_W:0] lt_chain;

    assign gt_chain[MAG_W] = 1'b0;
    assign lt_chain[MAG_W] = 1'b0;

    generate
        for (genvar i = MAG_W - 1; i >= 0; i--) begin : g_bit
            // Keep an earlier decision, otherwise decide on this bit.
            always_comb begin
                gt_chain[i] = gt_chain[i+1] | (~lt_chain[i+1] &  a_mag[i] & ~b_mag[i]);
                lt_chain[i] = lt_chain[i+1] | (~gt_chain[i+1] & ~a_mag[i] &  b_mag[i]);
            end
        end
    endgenerate

    // Final flags from the bottom of the chain.
    always_comb begin
        a_ge_b  = ~lt_chain[0];
        mag_tie = ~gt_chain[0] & ~lt_chain[0];
    end

endmodule

// File: rtl/smas_mag_core.sv
// Magnitude arithmetic core: either adds the two magnitudes or subtracts
// the smaller from the larger, and reports the carry out of an addition.
// Assumes: in subtract mode big_mag >= small_mag, so no borrow can occur.
module smas_mag_core #(
    parameter int MAG_W = 7
) (
    input  logic [MAG_W-1:0] big_mag,
    input  logic [MAG_W-1:0] small_mag,
    input  logic             do_add,
    output logic [MAG_W-1:0] mag_res,
    output logic             carry_out
);

    localparam int EXT_W = MAG_W + 1;

    logic [EXT_W-1:0] wide;

    // One extended-width add or subtract, selected by do_add.
    always_comb begin
        if (do_add) begin
            wide = {1'b0, big_mag} + {1'b0, small_mag};
        end else begin
            wide = {1'b0, big_mag} - {1'b0, small_mag};
        end
        mag_res   = wide[MAG_W-1:0];
        carry_out = do_add & wide[MAG_W];
    end

endmodule

// File: rtl/smas_addsub.sv
// Top level of the signed-magnitude adder/subtractor. Splits the operands,
// routes signs, orders the magnitudes, runs the core and rebuilds the result.
// Assumes: WIDTH >= 2; the block is combinational and has no clock or reset.
module smas_addsub #(
    parameter int WIDTH = 8
) (
    input  logic             sub_op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             overflow
);
    import smas_pkg::*;

    localparam int MAG_W = WIDTH - 1;

    smas_op_e         op_e;
    logic             a_sign;
    logic             b_sign;
    logic [MAG_W-1:0] a_mag;
    logic [MAG_W-1:0] b_mag;
    logic             eff_b_sign;
    logic             same_sign;
    logic             a_ge_b;
    logic             mag_tie;
    logic [MAG_W-1:0] big_mag;
    logic [MAG_W-1:0] small_mag;
    logic [MAG_W-1:0] mag_res;
    logic             carry_out;
    logic             res_sign;

    // Split operands into sign and magnitude and decode the operation.
    always_comb begin
        op_e   = smas_op_e'(sub_op);
        a_sign = opnd_a[WIDTH-1];
        b_sign = opnd_b[WIDTH-1];
        a_mag  = opnd_a[MAG_W-1:0];
        b_mag  = opnd_b[MAG_W-1:0];
    end

    smas_sign_route u_sign (
        .a_sign     (a_sign),
        .b_sign     (b_sign),
        .op         (op_e),
        .eff_b_sign (eff_b_sign),
        .same_sign  (same_sign)
    );

    smas_mag_cmp #(.MAG_W(MAG_W)) u_cmp (
        .a_mag   (a_mag),
        .b_mag   (b_mag),
        .a_ge_b  (a_ge_b),
        .mag_tie (mag_tie)
    );

    // Place the larger magnitude on the minuend side of the core.
    always_comb begin
        if (a_ge_b) begin
            big_mag   = a_mag;
            small_mag = b_mag;
        end else begin
            big_mag   = b_mag;
            small_mag = a_mag;
        end
    end

    smas_mag_core #(.MAG_W(MAG_W)) u_core (
        .big_mag   (big_mag),
        .small_mag (small_mag),
        .do_add    (same_sign),
        .mag_res   (mag_res),
        .carry_out (carry_out)
    );

    // Choose the result sign: the common sign, the larger operand's sign, or plus on a tie.
    always_comb begin
        if (same_sign) begin
            res_sign = a_sign;
        end else if (mag_tie) begin
            res_sign = 1'b0;
        end else if (a_ge_b) begin
            res_sign = a_sign;
        end else begin
            res_sign = eff_b_sign;
        end
    end

    // Rebuild the output word and flag.
    always_comb begin
        result   = {res_sign, mag_res};
        overflow = carry_out;
    end

endmodule

// File: rtl/smas_addsub_chk.sv
// Checker for smas_addsub: recomputes the sign-and-magnitude rules from the
// ports and compares them with the outputs.
// Assumes: combinational inputs have settled when the process wakes.
module smas_addsub_chk #(
    parameter int WIDTH = 8
) (
    input logic             sub_op,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             overflow
);
    localparam int MAG_W = WIDTH - 1;

    logic             sa;
    logic             sb_eff;
    logic [MAG_W-1:0] ma;
    logic [MAG_W-1:0] mb;
    logic [MAG_W:0]   msum;

    // Derive the effective signs and the magnitude sum from the ports.
    always_comb begin
        sa     = opnd_a[WIDTH-1];
        sb_eff = opnd_b[WIDTH-1] ^ sub_op;
        ma     = opnd_a[MAG_W-1:0];
        mb     = opnd_b[MAG_W-1:0];
        msum   = {1'b0, ma} + {1'b0, mb};
    end

    // Check each rule whenever an input or output moves.
    always_comb begin
        assert_no_overflow_R6: assert ((sa == sb_eff) || !overflow)
            else $error("R6: overflow raised on differing signs");
        assert_carry_flag_R3: assert ((sa != sb_eff) || (overflow == msum[MAG_W]))
            else $error("R3: overflow does not match magnitude carry");
        assert_common_sign_R2: assert ((sa != sb_eff) || (result[WIDTH-1] == sa))
            else $error("R2: result sign differs from common sign");
        assert_plus_zero_R5: assert ((sa == sb_eff) || (ma != mb) || (result == '0))
            else $error("R5: cancellation did not give plus zero");
        assert_larger_wins_R4: assert ((sa == sb_eff) || (ma <= mb) ||
                                       (result == {sa, ma - mb}))
            else $error("R4: larger-magnitude A not honoured");
    end

endmodule

bind smas_addsub smas_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .sub_op   (sub_op),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .overflow (overflow)
);

// File: tb/smas_addsub_tb.sv
`timescale 1ns/1ps
module smas_addsub_tb;

    localparam int W  = 5;
    localparam int M  = W - 1;
    localparam int MAXM = (1 << M) - 1;
    localparam int NVEC = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sub_op = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         overflow;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    smas_addsub #(.WIDTH(W)) u_dut (
        .sub_op   (sub_op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .overflow (overflow)
    );

    // Packed vector: {sub, a[4:0], b[4:0], exp_result[4:0], exp_ovf}
    localparam logic [16:0] VEC [NVEC] = '{
        17'b0_01011_00110_00001_1,  // R3: +11 + +6 wraps, overflow
        17'b0_01011_10110_00101_0,  // R4: +11 + -6 = +5
        17'b0_11011_00110_10101_0,  // R4: -11 + +6 = -5
        17'b0_00110_11011_10101_0,  // R4: +6 + -11 = -5
        17'b1_00111_00111_00000_0,  // R5 R7: +7 - +7 = +0
        17'b0_10111_00111_00000_0,  // R5: -7 + +7 = +0
        17'b0_10000_10000_10000_0,  // R8: -0 + -0 = -0
        17'b1_00000_00000_00000_0,  // R7: +0 - +0 = +0
        17'b1_10011_00100_10111_0,  // R7: -3 - +4 = -7
        17'b0_11111_10001_10000_1,  // R3: -15 + -1 overflow
        17'b0_01111_11111_00000_0,  // R1 R5: +15 + -15 = +0
        17'b1_01111_11111_01110_1,  // R7 R3: +15 - -15 overflow
        17'b1_00010_10011_00101_0,  // R7: +2 - -3 = +5
        17'b0_10000_00101_00101_0   // R8: -0 + +5 = +5
    };

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got res=%b ovf=%b, expected res=%b ovf=%b",
                     tag, act[W:1], act[0], exp[W:1], exp[0]);
        end
    endtask

    // Signed value of a sign-and-magnitude word.
    function automatic int sm_val(input logic [W-1:0] x);
        int mag;
        mag = int'(x[M-1:0]);
        return x[W-1] ? -mag : mag;
    endfunction

    task automatic apply(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        #1;
        sub_op = s;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // Reset phase: zero operands must give plus zero, no overflow (R1).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset idle", {result, overflow}, {{W{1'b0}}, 1'b0});
        rst_n = 1'b1;

        // Table of worked cases.
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][16], VEC[i][15:11], VEC[i][10:6]);
            check($sformatf("vector %0d (R2 R3 R4 R5 R7 R8)", i),
                  {result, overflow}, VEC[i][5:0]);
        end

        // Full sweep of every operation and operand pair.
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    logic [W-1:0] av;
                    logic [W-1:0] bv;
                    logic         sa;
                    logic         sbe;
                    int           ma;
                    int           mb;
                    int           sum;
                    logic [W-1:0] er;
                    logic         eo;
                    string        tag;
                    av  = W'(a);
                    bv  = W'(b);
                    sa  = av[W-1];
                    sbe = bv[W-1] ^ s[0];
                    ma  = int'(av[M-1:0]);
                    mb  = int'(bv[M-1:0]);
                    if (sa == sbe) begin
                        sum = ma + mb;
                        er  = {sa, M'(sum)};
                        eo  = (sum > MAXM);
                        tag = "R2 R3 same sign";
                    end else if (ma > mb) begin
                        er = {sa, M'(ma - mb)};
                        eo = 1'b0;
                        tag = "R4 A larger";
                    end else if (mb > ma) begin
                        er = {sbe, M'(mb - ma)};
                        eo = 1'b0;
                        tag = "R4 B larger";
                    end else begin
                        er = '0;
                        eo = 1'b0;
                        tag = "R5 tie";
                    end
                    apply(s[0], av, bv);
                    check($sformatf("%s sub=%0d a=%b b=%b", tag, s, av, bv),
                          {result, overflow}, {er, eo});
                    if (sa != sbe) begin
                        check("R6 no overflow on differing signs",
                              {{W{1'b0}}, overflow}, {{W{1'b0}}, 1'b0});
                    end
                    if (!overflow) begin
                        int ev;
                        ev = (s == 1) ? sm_val(av) - sm_val(bv) : sm_val(av) + sm_val(bv);
                        n_checks++;
                        if (sm_val(result) != ev) begin
                            n_errors++;
                            $display("FAIL R9 value: got %0d, expected %0d", sm_val(result), ev);
                        end
                    end
                end
            end
        end

        // Directed corner: negation via R7 of minus zero, and R8 sign handling.
        apply(1'b1, 5'b00000, 5'b10000);
        check("R8 R7 +0 - -0", {result, overflow}, {5'b00000, 1'b0});
        apply(1'b0, 5'b01111, 5'b01111);
        check("R3 +15 + +15 max wrap", {result, overflow}, {5'b01110, 1'b1});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule